// File: doc/BRIEF.md
# Call-Stack Recorder Control Register

This block is the 64-bit control and status register of a hardware call-stack recorder that runs at privilege level 0. Software reaches it through a plain register port. Each access on that port carries the privilege level of the requester (0 to 3). The register holds:

- a recorder enable;
- two sticky flags, overflow and underflow, which the recorder sets with one-cycle pulses;
- a store-privilege select;
- a privileged-access-never bit;
- a 6-bit buffer-size code.

The block drives the recorder datapath with the stored enable, the stored flags, the effective privilege controls and the buffer size decoded to a byte count.

The effective privilege controls are not always the stored bits. Disabled first-stage translation overrides them. So does a first-stage description that lacks level-0 permissions, and so does the level-0 enable field that governs the current regime. That field is taken from level 1, or from level 2 when level 2 is enabled and the host-mode flag pair is {1,1}. A level-0 requester sees the two privilege bits as fixed constants and cannot change them. A reserved size code is kept and read back exactly as written, but the recorder is given the smallest legal buffer.

Top module: `callrec_ctl`

## Requirements
- R1: Bits 63:11 of the read data are always 0, and the bits written there are discarded.
- R2: A write from any level stores EN (bit 0), OF (bit 1), UF (bit 2) and SIZE (bits 9:4). A write from levels 1 to 3 also stores NP (bit 3) and PAN (bit 10). Reads from levels 1 to 3 return the stored fields, and the outputs `rec_en`, `rec_ovf` and `rec_unf` follow the stored bits. A write becomes visible one cycle after the clock edge that takes it.
- R3: A synchronous reset (`rst_n` low at a clock edge) clears EN to 0. The other fields are not initialised by reset.
- R4: A read from level 0 returns 0 in bit 10 and 1 in bit 3. A write from level 0 leaves the stored PAN and NP unchanged.
- R5: A one-cycle pulse on `ovf_set` or `unf_set` sets the matching flag, and the flag stays set until a write loads it. When a set pulse and a write of 0 arrive in the same cycle, the flag ends up set.
- R6: Each legal SIZE code gives `buf_bytes` = 2^code. The legal codes are 9, 10, 11, 12, 14, 16 and 21, which give 512 B, 1 KB, 2 KB, 4 KB, 16 KB, 64 KB and 2 MB.
- R7: Any other SIZE code reads back exactly as written, and `buf_bytes` is then 512.
- R8: `eff_pan_never` equals the stored PAN bit, forced to 0 while `xlat_off` or `perm_missing` is 1.
- R9: `eff_unpriv` equals the stored NP bit, forced to 1 while `xlat_off` is 1 or while the governing level-0 enable field equals 2'b11.
- R10: The governing field is `l2_ena` when `l2_on` = 1 and `host_pair` = 2'b11. In every other case it is `l1_ena`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_lvl | input | 2 | Privilege level of the current access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Read data as seen from `acc_lvl` (combinational) |
| ovf_set | input | 1 | Overflow set pulse from the recorder |
| unf_set | input | 1 | Underflow set pulse from the recorder |
| xlat_off | input | 1 | First-stage translation is disabled |
| perm_missing | input | 1 | First stage does not describe level-0 permissions |
| l2_on | input | 1 | Level 2 is enabled |
| host_pair | input | 2 | Host-mode flag pair |
| l1_ena | input | 2 | Level-0 enable field held at level 1 |
| l2_ena | input | 2 | Level-0 enable field held at level 2 |
| rec_en | output | 1 | Stored recorder enable |
| rec_ovf | output | 1 | Stored overflow flag |
| rec_unf | output | 1 | Stored underflow flag |
| eff_unpriv | output | 1 | Effective store-privilege select (1 = unprivileged) |
| eff_pan_never | output | 1 | Effective privileged-access-never |
| buf_bytes | output | 22 | Effective buffer size in bytes |

## Verification
Stored fields, and the outputs that depend on them, change at the clock edge that accepts a write or a set pulse. The bench drives its inputs on the falling edge and holds them through one rising edge. It then samples at the next falling edge, so every stored result is checked one cycle after its stimulus. Read data, the effective privilege outputs and the decoded size depend combinationally on the access level and on the translation inputs. Those results are sampled 1 ns after the inputs change, with no clock edge in between.

// File: rtl/callrec_pkg.sv
// Shared constants and the size-code legality function for the call-stack
// recorder control register. Assumes a 6-bit size code.
package callrec_pkg;
    localparam int REG_W    = 64;
    localparam int CODE_W   = 6;
    localparam int POS_EN   = 0;
    localparam int POS_OF   = 1;
    localparam int POS_UF   = 2;
    localparam int POS_NP   = 3;
    localparam int POS_SZ   = 4;
    localparam int POS_PAN  = 10;
    localparam int USED_W   = POS_PAN + 1;
    localparam int MIN_CODE = 9;

    // Purpose: tell whether a size code selects a legal buffer size.
    function automatic logic size_code_legal(input logic [CODE_W-1:0] code);
        case (code)
            6'd9, 6'd10, 6'd11, 6'd12, 6'd14, 6'd16, 6'd21: return 1'b1;
            default:                                         return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/callrec_size_dec.sv
// Converts the stored size code to a byte count. Assumes BYTES_W covers
// 2^(largest legal code). A reserved code maps to the smallest legal size.
module callrec_size_dec
    import callrec_pkg::*;
#(
    parameter int BYTES_W = 22
) (
    input  logic [CODE_W-1:0]  code,
    output logic [BYTES_W-1:0] bytes
);
    // Purpose: pick the effective code and turn it into a power of two.
    always_comb begin
        if (size_code_legal(code))
            bytes = BYTES_W'(1) << code;
        else
            bytes = BYTES_W'(1) << MIN_CODE;
    end
endmodule

// File: rtl/callrec_sticky.sv
// A bank of sticky flags. A set pulse forces a flag to 1. A write loads it
// from the write data. When both happen in one cycle, the set pulse wins.
// Assumes the flags need no reset value.
module callrec_sticky #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic [N-1:0] set_p,
    input  logic         wr,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // Purpose: hold one flag, with the set pulse taking priority.
        always_ff @(posedge clk) begin
            if (set_p[i])
                q[i] <= 1'b1;
            else if (wr)
                q[i] <= wdata[i];
        end
    end
endmodule

// File: rtl/callrec_eff.sv
// Derives the effective privilege controls from the stored bits, the
// translation state and the governing level-0 enable field.
module callrec_eff #(
    parameter int ENA_W = 2
) (
    input  logic             pan_q,
    input  logic             np_q,
    input  logic             xlat_off,
    input  logic             perm_missing,
    input  logic             l2_on,
    input  logic [1:0]       host_pair,
    input  logic [ENA_W-1:0] l1_ena,
    input  logic [ENA_W-1:0] l2_ena,
    output logic             eff_pan_never,
    output logic             eff_unpriv
);
    localparam logic [ENA_W-1:0] ENA_ALL = '1;
    logic [ENA_W-1:0] gov;

    // Purpose: choose which enable field governs level 0.
    always_comb gov = (l2_on && host_pair == 2'b11) ? l2_ena : l1_ena;

    // Purpose: apply the overrides to the stored PAN and NP bits.
    always_comb begin
        eff_pan_never = pan_q && !xlat_off && !perm_missing;
        eff_unpriv    = np_q || xlat_off || (gov == ENA_ALL);
    end
endmodule

// File: rtl/callrec_ctl.sv
// Top of the call-stack recorder control register. It stores the fields,
// serves level-tagged reads and writes and drives the effective values to
// the recorder. Read data is combinational from acc_lvl. Only EN is reset.
module callrec_ctl
    import callrec_pkg::*;
#(
    parameter int BYTES_W = 22
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         acc_lvl,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    output logic [REG_W-1:0]   rd_data,
    input  logic               ovf_set,
    input  logic               unf_set,
    input  logic               xlat_off,
    input  logic               perm_missing,
    input  logic               l2_on,
    input  logic [1:0]         host_pair,
    input  logic [1:0]         l1_ena,
    input  logic [1:0]         l2_ena,
    output logic               rec_en,
    output logic               rec_ovf,
    output logic               rec_unf,
    output logic               eff_unpriv,
    output logic               eff_pan_never,
    output logic [BYTES_W-1:0] buf_bytes
);
    logic              en_q, np_q, pan_q;
    logic [CODE_W-1:0] size_q;
    logic [1:0]        flags_q;
    logic              lvl0;
    logic              unused_hi;

    assign lvl0      = (acc_lvl == 2'd0);
    assign unused_hi = ^wr_data[REG_W-1:USED_W];

    // Purpose: hold the enable bit, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b0;
        else if (wr_en)
            en_q <= wr_data[POS_EN];
    end

    // Purpose: hold the size code, written from any level.
    always_ff @(posedge clk) begin
        if (wr_en)
            size_q <= wr_data[POS_SZ +: CODE_W];
    end

    // Purpose: hold PAN and NP, which level 0 cannot write.
    always_ff @(posedge clk) begin
        if (wr_en && !lvl0) begin
            np_q  <= wr_data[POS_NP];
            pan_q <= wr_data[POS_PAN];
        end
    end

    callrec_sticky #(.N(2)) u_flags (
        .clk   (clk),
        .set_p ({unf_set, ovf_set}),
        .wr    (wr_en),
        .wdata ({wr_data[POS_UF], wr_data[POS_OF]}),
        .q     (flags_q)
    );

    callrec_eff #(.ENA_W(2)) u_eff (
        .pan_q         (pan_q),
        .np_q          (np_q),
        .xlat_off      (xlat_off),
        .perm_missing  (perm_missing),
        .l2_on         (l2_on),
        .host_pair     (host_pair),
        .l1_ena        (l1_ena),
        .l2_ena        (l2_ena),
        .eff_pan_never (eff_pan_never),
        .eff_unpriv    (eff_unpriv)
    );

    callrec_size_dec #(.BYTES_W(BYTES_W)) u_size (
        .code  (size_q),
        .bytes (buf_bytes)
    );

    // Purpose: build the read view, with fixed PAN and NP for level 0.
    always_comb begin
        rd_data                   = '0;
        rd_data[POS_EN]           = en_q;
        rd_data[POS_OF]           = flags_q[0];
        rd_data[POS_UF]           = flags_q[1];
        rd_data[POS_NP]           = lvl0 ? 1'b1 : np_q;
        rd_data[POS_SZ +: CODE_W] = size_q;
        rd_data[POS_PAN]          = lvl0 ? 1'b0 : pan_q;
    end

    // Purpose: expose the stored state bits to the recorder.
    always_comb begin
        rec_en  = en_q;
        rec_ovf = flags_q[0];
        rec_unf = flags_q[1];
    end
endmodule

// File: rtl/callrec_ctl_chk.sv
// Property checker for callrec_ctl, attached to it with bind.
module callrec_ctl_chk
    import callrec_pkg::*;
#(
    parameter int BYTES_W = 22
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         acc_lvl,
    input logic               wr_en,
    input logic [REG_W-1:0]   rd_data,
    input logic               ovf_set,
    input logic               unf_set,
    input logic               xlat_off,
    input logic               perm_missing,
    input logic               rec_en,
    input logic               rec_ovf,
    input logic               rec_unf,
    input logic               eff_unpriv,
    input logic               eff_pan_never,
    input logic [BYTES_W-1:0] buf_bytes
);
    logic rst_seen_q;

    // Purpose: remember whether the previous edge was in reset.
    always_ff @(posedge clk) rst_seen_q <= rst_n;

    // R1
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[REG_W-1:USED_W] == '0);
    // R3
    en_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_seen_q |-> !rec_en);
    // R4
    lvl0_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_lvl == 2'd0 |-> (!rd_data[POS_PAN] && rd_data[POS_NP]));
    // R5
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |=> rec_ovf);
    // R5
    unf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf_set |=> rec_unf);
    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !ovf_set && !unf_set) |=> ($stable(rec_ovf) && $stable(rec_unf)));
    // R6
    bytes_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(buf_bytes) == 1 && buf_bytes >= BYTES_W'(512));
    // R7
    rsvd_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !size_code_legal(rd_data[POS_SZ +: CODE_W]) |-> buf_bytes == BYTES_W'(512));
    // R8
    pan_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xlat_off || perm_missing) |-> !eff_pan_never);
    // R9
    np_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_off |-> eff_unpriv);
endmodule

bind callrec_ctl callrec_ctl_chk #(.BYTES_W(BYTES_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .acc_lvl       (acc_lvl),
    .wr_en         (wr_en),
    .rd_data       (rd_data),
    .ovf_set       (ovf_set),
    .unf_set       (unf_set),
    .xlat_off      (xlat_off),
    .perm_missing  (perm_missing),
    .rec_en        (rec_en),
    .rec_ovf       (rec_ovf),
    .rec_unf       (rec_unf),
    .eff_unpriv    (eff_unpriv),
    .eff_pan_never (eff_pan_never),
    .buf_bytes     (buf_bytes)
);

// File: tb/sim_callrec_ctl.sv
// Directed bench for callrec_ctl: one task per scenario.
module sim_callrec_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  acc_lvl = 2'd1;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_data;
    logic        ovf_set = 1'b0, unf_set = 1'b0;
    logic        xlat_off = 1'b0, perm_missing = 1'b0, l2_on = 1'b0;
    logic [1:0]  host_pair = 2'b00, l1_ena = 2'b00, l2_ena = 2'b00;
    logic        rec_en, rec_ovf, rec_unf, eff_unpriv, eff_pan_never;
    logic [21:0] buf_bytes;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    callrec_ctl u0 (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Bits: PAN 10, SIZE 9:4, NP 3, UF 2, OF 1, EN 0.
    function automatic logic [63:0] pack(input logic pan, input logic [5:0] sz,
                                         input logic np, input logic uf,
                                         input logic of_b, input logic en);
        return {53'd0, pan, sz, np, uf, of_b, en};
    endfunction

    function automatic logic [21:0] exp_bytes(input logic [5:0] c);
        case (c)
            6'd9, 6'd10, 6'd11, 6'd12, 6'd14, 6'd16, 6'd21: return 22'd1 << c;
            default: return 22'd512;
        endcase
    endfunction

    task automatic wr(input logic [1:0] lvl, input logic [63:0] d);
        @(negedge clk);
        acc_lvl = lvl; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] lvl, output logic [63:0] d);
        acc_lvl = lvl;
        #1 d = rd_data;
    endtask

    task automatic t_reset();
        logic [63:0] d;
        wr_data = 64'd1; wr_en = 1'b1;
        repeat (3) @(negedge clk);
        wr_en = 1'b0;
        rst_n = 1'b1;
        chk("R3 reset EN", rec_en, 0);
        rd(2'd1, d);
        chk("R3 reset read EN", d[0], 0);
    endtask

    task automatic t_layout();
        logic [63:0] d;
        wr(2'd1, pack(1'b1, 6'd12, 1'b0, 1'b1, 1'b0, 1'b1));
        rd(2'd1, d);
        chk("R2 readback lvl1", d, pack(1'b1, 6'd12, 1'b0, 1'b1, 1'b0, 1'b1));
        chk("R2 rec_en", rec_en, 1);
        chk("R2 rec_unf", rec_unf, 1);
        chk("R2 rec_ovf", rec_ovf, 0);
        wr(2'd3, pack(1'b0, 6'd10, 1'b1, 1'b0, 1'b1, 1'b0));
        rd(2'd2, d);
        chk("R2 readback lvl3 write", d, pack(1'b0, 6'd10, 1'b1, 1'b0, 1'b1, 1'b0));
        chk("R2 rec_ovf", rec_ovf, 1);
    endtask

    task automatic t_rsvd_bits();
        logic [63:0] d;
        wr(2'd1, 64'hFFFF_FFFF_FFFF_F800 | pack(1'b0, 6'd9, 1'b0, 1'b0, 1'b0, 1'b1));
        rd(2'd1, d);
        chk("R1 upper bits read zero", d[63:11], 0);
        chk("R1 low fields intact", d, pack(1'b0, 6'd9, 1'b0, 1'b0, 1'b0, 1'b1));
    endtask

    task automatic t_level0();
        logic [63:0] d;
        wr(2'd1, pack(1'b1, 6'd9, 1'b0, 1'b0, 1'b0, 1'b0));
        rd(2'd0, d);
        chk("R4 lvl0 PAN reads 0", d[10], 0);
        chk("R4 lvl0 NP reads 1", d[3], 1);
        wr(2'd0, pack(1'b0, 6'd11, 1'b1, 1'b0, 1'b0, 1'b1));
        rd(2'd1, d);
        chk("R4 lvl0 write keeps PAN/NP", d, pack(1'b1, 6'd11, 1'b0, 1'b0, 1'b0, 1'b1));
    endtask

    task automatic t_flags();
        logic [63:0] d;
        wr(2'd1, pack(1'b0, 6'd9, 1'b0, 1'b0, 1'b0, 1'b1));
        @(negedge clk); ovf_set = 1'b1;
        @(negedge clk); ovf_set = 1'b0;
        chk("R5 ovf set by pulse", rec_ovf, 1);
        chk("R5 unf untouched", rec_unf, 0);
        repeat (4) @(negedge clk);
        chk("R5 ovf sticky", rec_ovf, 1);
        @(negedge clk);
        acc_lvl = 2'd1; wr_data = pack(1'b0, 6'd9, 1'b0, 1'b0, 1'b0, 1'b1);
        wr_en = 1'b1; ovf_set = 1'b1; unf_set = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; ovf_set = 1'b0; unf_set = 1'b0;
        chk("R5 set beats clear ovf", rec_ovf, 1);
        chk("R5 set beats clear unf", rec_unf, 1);
        wr(2'd0, pack(1'b0, 6'd9, 1'b0, 1'b0, 1'b0, 1'b1));
        chk("R5 write clears ovf", rec_ovf, 0);
        rd(2'd1, d);
        chk("R5 write clears unf", d[2], 0);
    endtask

    task automatic t_sizes();
        logic [63:0] d;
        for (int c = 0; c < 64; c++) begin
            wr(2'd1, pack(1'b0, 6'(c), 1'b0, 1'b0, 1'b0, 1'b0));
            rd(2'd1, d);
            chk("R7 size reads back", d[9:4], 64'(c));
            chk((exp_bytes(6'(c)) == (22'd1 << c)) ? "R6 legal size bytes" : "R7 reserved size bytes",
                buf_bytes, exp_bytes(6'(c)));
        end
    endtask

    task automatic t_pan();
        wr(2'd1, pack(1'b1, 6'd9, 1'b0, 1'b0, 1'b0, 1'b0));
        xlat_off = 0; perm_missing = 0;
        #1 chk("R8 PAN passes", eff_pan_never, 1);
        xlat_off = 1;
        #1 chk("R8 xlat_off forces 0", eff_pan_never, 0);
        xlat_off = 0; perm_missing = 1;
        #1 chk("R8 perm_missing forces 0", eff_pan_never, 0);
        perm_missing = 0;
        wr(2'd1, pack(1'b0, 6'd9, 1'b0, 1'b0, 1'b0, 1'b0));
        chk("R8 stored 0", eff_pan_never, 0);
    endtask

    task automatic t_np();
        wr(2'd1, pack(1'b0, 6'd9, 1'b0, 1'b0, 1'b0, 1'b0));
        xlat_off = 0; l2_on = 0; host_pair = 2'b00; l1_ena = 2'b01; l2_ena = 2'b11;
        #1 chk("R9 stored NP 0 passes", eff_unpriv, 0);
        xlat_off = 1;
        #1 chk("R9 xlat_off forces 1", eff_unpriv, 1);
        xlat_off = 0; l1_ena = 2'b11;
        #1 chk("R9 l1 field 11 forces 1", eff_unpriv, 1);
        l1_ena = 2'b10; l2_on = 1; host_pair = 2'b11;
        #1 chk("R10 l2 field governs in host mode", eff_unpriv, 1);
        l2_ena = 2'b01;
        #1 chk("R10 l2 field 01 no force", eff_unpriv, 0);
        l1_ena = 2'b11;
        #1 chk("R10 l1 field ignored in host mode", eff_unpriv, 0);
        host_pair = 2'b10; l2_ena = 2'b11; l1_ena = 2'b00;
        #1 chk("R10 l1 governs when pair not 11", eff_unpriv, 0);
        l2_on = 0; host_pair = 2'b11;
        #1 chk("R10 l1 governs when l2 off", eff_unpriv, 0);
        wr(2'd2, pack(1'b0, 6'd9, 1'b1, 1'b0, 1'b0, 1'b0));
        chk("R9 stored NP 1", eff_unpriv, 1);
    endtask

    initial begin
        t_reset();
        t_layout();
        t_rsvd_bits();
        t_level0();
        t_flags();
        t_sizes();
        t_pan();
        t_np();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule